// File: doc/BRIEF.md
# Serial-In Latched Sink Driver Register

This block takes a serial bit stream and presents it as eight parallel sink-enable controls. It has two register stages with separate clocks. A shift stage loads one bit per rising edge of the shift clock. A storage stage takes a snapshot of the shift stage on each rising edge of the latch clock. The storage stage then drives eight sink-enable outputs through a common blanking gate. The bit leaving the far end of the shift stage appears on a cascade output. Any number of blocks can therefore share the two clocks, with each block's cascade output wired to the serial input of the next.

Two controls act without a clock. An active-low clear empties the shift stage and leaves the storage stage alone. An active-low output enable, when released high, turns every sink off and disturbs neither stage. A host can therefore load new data while the outputs keep showing the old pattern. It can also blank the outputs and later restore them without sending the data again.

Top module: `latch_sink_driver`

## Requirements
- R1: On each rising edge of `shiftClk` while `clearN` is high, the shift stage moves one place toward the cascade end. Position 0 takes `serIn`, and `serOut` shows position 7, the last position.
- R2: On each rising edge of `latchClk`, the storage stage copies the shift stage. Shift edges alone never change `sinkOn`.
- R3: While `clearN` is low, the shift stage is all zeros at once, with no clock edge needed. So `serOut` is 0, and a latch edge during the clear stores zeros.
- R4: Clearing the shift stage leaves the storage stage unchanged, so `sinkOn` keeps its value through a clear.
- R5: While `outEnN` is high, all eight bits of `sinkOn` are 0. The storage contents are kept, and they reappear when `outEnN` returns low.
- R6: While `outEnN` is low, `sinkOn[i]` equals storage bit i. A 1 means the sink is on.
- R7: After eight shifts, the first of the eight bits shifted in sits at `sinkOn[7]` and the last sits at `sinkOn[0]`.
- R8: When two blocks are chained through `serOut`, sixteen shifts followed by one latch put the first eight bits in the far block and the last eight bits in the near block.
- R9: When `shiftClk` and `latchClk` rise at the same instant, the storage stage captures the shift contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shiftClk | input | 1 | Shift stage clock, rising edge |
| latchClk | input | 1 | Storage stage clock, rising edge |
| clearN | input | 1 | Asynchronous clear of the shift stage, active low |
| outEnN | input | 1 | Output enable, active low; high blanks all sinks |
| serIn | input | 1 | Serial data into shift position 0 |
| sinkOn | output | 8 | Sink-enable per driver, 1 = on |
| serOut | output | 1 | Cascade output, last shift position |

## Verification
The hardest case to reach is a shift edge and a latch edge at the same instant. A bench that drives one clock and then the other never exercises it. The stimulus raises both clocks in one assignment step, then latches again on its own. Comparing the two snapshots shows that the first one holds the contents from before the shift. A second hard case is showing that a clear or a blanked output leaves the storage stage intact. The bench does this through the ports: it latches a known pattern, then clears or blanks, then re-enables and reads the same pattern back on `sinkOn`.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;

  // Level strobes handed from control decode to the datapath
  typedef struct packed {
    logic clrShift;  // empty the shift stage
    logic blankOut;  // force all sinks off
  } drv_strobe_t;

endpackage

// File: rtl/sink_drv_ctrl.sv
module sink_drv_ctrl
  import sink_drv_pkg::*;
(
  input  logic        clearN,
  input  logic        outEnN,
  output drv_strobe_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.clrShift = ~clearN;
    strobes.blankOut = outEnN;
  end

endmodule

// File: rtl/sink_drv_path.sv
module sink_drv_path
  import sink_drv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             serIn,
  input  drv_strobe_t      strobes,
  output logic [WIDTH-1:0] sinkOn,
  output logic             serOut,
  output logic [WIDTH-1:0] shiftState,
  output logic [WIDTH-1:0] storeState
);

  localparam int LAST = WIDTH - 1;

  logic             clrShift;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  assign clrShift = strobes.clrShift;

  // shift stage, asynchronous clear
  always_ff @(posedge shiftClk or posedge clrShift) begin
    if (clrShift) shiftQ <= '0;
    else          shiftQ <= {shiftQ[LAST-1:0], serIn};
  end

  // storage stage, no clear
  always_ff @(posedge latchClk) begin
    storeQ <= shiftQ;
  end

  // per-driver output gate
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign sinkOn[i] = storeQ[i] & ~strobes.blankOut;
  end

  assign serOut     = shiftQ[LAST];
  assign shiftState = shiftQ;
  assign storeState = storeQ;

endmodule

// File: rtl/latch_sink_driver.sv
module latch_sink_driver
  import sink_drv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             clearN,
  input  logic             outEnN,
  input  logic             serIn,
  output logic [WIDTH-1:0] sinkOn,
  output logic             serOut
);

  drv_strobe_t      strobes;
  logic [WIDTH-1:0] shiftState;
  logic [WIDTH-1:0] storeState;

  sink_drv_ctrl u_ctrl (
    .clearN  (clearN),
    .outEnN  (outEnN),
    .strobes (strobes)
  );

  sink_drv_path #(.WIDTH(WIDTH)) u_path (
    .shiftClk   (shiftClk),
    .latchClk   (latchClk),
    .serIn      (serIn),
    .strobes    (strobes),
    .sinkOn     (sinkOn),
    .serOut     (serOut),
    .shiftState (shiftState),
    .storeState (storeState)
  );

endmodule

// File: rtl/sink_drv_chk.sv
module sink_drv_chk #(
  parameter int WIDTH = 8
) (
  input logic             shiftClk,
  input logic             latchClk,
  input logic             clearN,
  input logic             outEnN,
  input logic             serIn,
  input logic [WIDTH-1:0] sinkOn,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] storeQ
);

  logic shiftSeen;
  logic latchSeen = 1'b0;

  always_ff @(posedge shiftClk or negedge clearN) begin
    if (!clearN) shiftSeen <= 1'b0;
    else         shiftSeen <= 1'b1;
  end

  always_ff @(posedge latchClk) latchSeen <= 1'b1;

  // R1
  shift_step_chk: assert property (@(posedge shiftClk) disable iff (!clearN)
    shiftSeen |-> shiftQ == {$past(shiftQ[WIDTH-2:0]), $past(serIn)});

  // R2
  latch_copy_chk: assert property (@(posedge latchClk) disable iff (!latchSeen)
    1'b1 |-> storeQ == $past(shiftQ));

  // R3
  clear_empty_chk: assert property (@(posedge latchClk) disable iff (!latchSeen)
    !clearN |-> shiftQ == '0);

  // R5
  blank_off_chk: assert property (@(posedge shiftClk) disable iff (!clearN)
    outEnN |-> sinkOn == '0);

  // R6
  follow_store_chk: assert property (@(posedge shiftClk) disable iff (!clearN)
    !outEnN |-> sinkOn == storeQ);

endmodule

bind latch_sink_driver sink_drv_chk #(.WIDTH(WIDTH)) u_chk (
  .shiftClk (shiftClk),
  .latchClk (latchClk),
  .clearN   (clearN),
  .outEnN   (outEnN),
  .serIn    (serIn),
  .sinkOn   (sinkOn),
  .shiftQ   (shiftState),
  .storeQ   (storeState)
);

// File: tb/test_latch_sink_driver.sv
module test_latch_sink_driver;

  logic       clk = 1'b0;
  logic       shiftClk = 1'b0;
  logic       latchClk = 1'b0;
  logic       clearN = 1'b0;
  logic       outEnN = 1'b1;
  logic       serIn = 1'b0;
  logic [7:0] sinkNear, sinkFar;
  logic       serNear, serFar;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  // near block receives serIn; far block is fed from near serOut
  latch_sink_driver i_latch_sink_driver (
    .shiftClk (shiftClk), .latchClk (latchClk), .clearN (clearN),
    .outEnN (outEnN), .serIn (serIn), .sinkOn (sinkNear), .serOut (serNear));

  latch_sink_driver i_latch_sink_driver_far (
    .shiftClk (shiftClk), .latchClk (latchClk), .clearN (clearN),
    .outEnN (outEnN), .serIn (serNear), .sinkOn (sinkFar), .serOut (serFar));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b;
    @(negedge clk); shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
  endtask

  task automatic latchPulse();
    @(negedge clk); latchClk = 1'b1;
    @(negedge clk); latchClk = 1'b0;
  endtask

  // most significant bit first
  task automatic shiftWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [15:0] w, prev;
    settle();
    // reset state: blanked, shift stage cleared
    chk("R5 reset blank near", sinkNear, 0);
    chk("R5 reset blank far", sinkFar, 0);
    chk("R3 reset serOut", serNear, 0);

    clearN = 1'b1;
    latchPulse();       // store zeros
    outEnN = 1'b0;
    settle();
    chk("R6 zero store near", sinkNear, 0);

    prev = 16'h0000;
    for (int k = 0; k < 256; k++) begin
      w = {k[7:0], (k[7:0] ^ 8'hA5) + 8'd3};
      shiftWord(w);
      settle();
      chk("R2 hold before latch near", sinkNear, prev[7:0]);
      chk("R2 hold before latch far", sinkFar, prev[15:8]);
      chk("R1 serOut near", serNear, w[7]);
      chk("R8 serOut far", serFar, w[15]);
      latchPulse();
      settle();
      chk("R8 near byte", sinkNear, w[7:0]);
      chk("R8 far byte", sinkFar, w[15:8]);
      prev = w;
    end

    // R7: single one followed by seven zeros
    shiftBit(1'b1);
    for (int i = 0; i < 7; i++) shiftBit(1'b0);
    latchPulse();
    settle();
    chk("R7 first bit at sink 7", sinkNear, 8'h80);
    chk("R8 far gets old near", sinkFar, prev[7:0]);

    // R4 / R3: clear keeps storage, empties shift stage without clock
    w = 16'hC35A;
    shiftWord(w);
    latchPulse();
    settle();
    clearN = 1'b0;
    #1;
    chk("R3 async clear serOut", serNear, 0);
    settle();
    chk("R4 store kept near", sinkNear, 8'h5A);
    chk("R4 store kept far", sinkFar, 8'hC3);
    latchPulse();
    settle();
    chk("R3 latch during clear near", sinkNear, 0);
    chk("R3 latch during clear far", sinkFar, 0);
    shiftBit(1'b1);
    settle();
    chk("R3 shift ignored under clear", serNear, 0);
    clearN = 1'b1;

    // R5: blanking keeps storage
    w = 16'h9E21;
    shiftWord(w);
    latchPulse();
    outEnN = 1'b1;
    settle();
    chk("R5 blank near", sinkNear, 0);
    chk("R5 blank far", sinkFar, 0);
    shiftWord(16'h0F0F);
    settle();
    chk("R5 blank while shifting", sinkNear, 0);
    outEnN = 1'b0;
    settle();
    chk("R5 restore near", sinkNear, 8'h21);
    chk("R5 restore far", sinkFar, 8'h9E);

    // R9: coincident edges store pre-shift contents
    w = 16'h6B94;
    shiftWord(w);
    @(negedge clk); serIn = 1'b1;
    @(negedge clk); shiftClk = 1'b1; latchClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0; latchClk = 1'b0;
    settle();
    chk("R9 coincident near", sinkNear, 8'h94);
    chk("R9 coincident far", sinkFar, 8'h6B);
    latchPulse();
    settle();
    chk("R9 shifted near", sinkNear, {w[6:0], 1'b1});
    chk("R9 shifted far", sinkFar, w[14:7]);

    finish();
  end

endmodule